// File: doc/BRIEF.md
# Ones' Complement Checksum Engine

This block computes a ones' complement checksum over a stream of fixed-width words, in the style used by Internet protocols. It adds each accepted word to a running sum. Any carry out of the top bit is added back in at bit 0 in the same cycle, so the stored sum is always a properly folded ones' complement value. A message begins with a start pulse and ends with a word marked last.

In generate mode, the block reports the bitwise inverse of the final sum as the checksum to transmit. In check mode, the caller streams the data words together with the received checksum word. The block then reports pass when the total is all ones, and fail otherwise. A failed message is meant to be dropped. The result and a one-cycle done strobe appear in the cycle after the last word. The checksum has known blind spots, and the bench shows that they really go undetected: reordered words, inserted words of all zeros or all ones, and same-position bit flips in opposite directions in two words.

Top module: `oc_csum_engine`

## Requirements
- R1: A start pulse discards the previous running sum. The word accepted together with start is the first word of the new message, so the sum after it equals that word.
- R2: Each accepted word is added with end-around carry. For example, with 16-bit words, 0xFFFF + 0x0001 gives 0x0001 and 0x8000 + 0x8000 gives 0x0001. A nonzero running sum never becomes zero when further words are added.
- R3: Words are taken only while in_valid is 1. Cycles with in_valid at 0 leave the sum unchanged, whatever is on in_word.
- R4: done is 1 for exactly the one cycle after a cycle in which in_valid and in_last are both 1. It is 0 at every other time. csum_out, pass and fail update in that same cycle and then hold until the next done.
- R5: In generate mode (in_mode = 0), csum_out equals the bitwise inverse of the ones' complement sum of the message words.
- R6: In check mode (in_mode = 1), pass is 1 when the sum of all the words equals all ones, and fail is 1 otherwise. Exactly one of the two is set. in_mode is sampled with the last word.
- R7: In generate mode, pass and fail are both 0 after done.
- R8: Reordering the words of a message does not change the checksum.
- R9: Inserting words of 0x0000 or all ones into a message that holds at least one nonzero word does not change the checksum.
- R10: A single flipped bit makes a check fail. Two flips of the same bit position, one 0 to 1 and one 1 to 0 in two different words, still pass.
- R11: The word width is the parameter W. With W = 8, both modes give the arithmetically expected result for every operand pair swept.
- R12: After reset, done, pass and fail are 0 and csum_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the running sum; the word in this cycle, if valid, begins the message |
| in_mode | input | 1 | 0 = generate checksum, 1 = check message; sampled with the last word |
| in_valid | input | 1 | in_word is taken this cycle |
| in_last | input | 1 | Marks the final word of a message |
| in_word | input | W | Data or received checksum word |
| csum_out | output | W | Inverse of the final sum |
| pass | output | 1 | Check mode: the total was all ones |
| fail | output | 1 | Check mode: the total was not all ones |
| done | output | 1 | One-cycle strobe, one cycle after the last word |

## Verification
On every cycle, the assertions check the following: the sum holds across idle cycles, a nonzero sum stays nonzero once folded, done is tied one-to-one to the last word, pass and fail are never set together, and generate mode keeps both low. Only the bench's scenarios can show the arithmetic itself: the folded carries, the correct inverse, and the check-mode verdicts over a sweep of 8-bit operand pairs. They also show the checksum's blind spots, such as swapped words, inserted zero and all-ones words, and cancelling bit flips, each compared against a model in the bench.

// File: rtl/oc_csum_pkg.sv
package oc_csum_pkg;
   typedef enum logic {
      CS_GEN = 1'b0,
      CS_CHK = 1'b1
   } cs_mode_e;

   localparam int CS_IMPL_WIDE  = 0;
   localparam int CS_IMPL_CMPCY = 1;
endpackage

// File: rtl/oc_fold_add.sv
module oc_fold_add #(
   parameter int W        = 16,
   parameter int ADD_IMPL = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   import oc_csum_pkg::*;

   generate
      if (W < 4) begin : g_bad_width
         $error("oc_fold_add: W must be at least 4");
      end
      if (ADD_IMPL == CS_IMPL_WIDE) begin : g_wide
         // one extra bit catches the carry, which is then added back at bit 0
         logic [W:0] wide;
         always_comb begin
            wide = {1'b0, a} + {1'b0, b};
            y    = wide[W-1:0] + W'(wide[W]);
         end
      end else if (ADD_IMPL == CS_IMPL_CMPCY) begin : g_cmpcy
         // a carry happens exactly when a exceeds the complement of b
         logic cy;
         always_comb begin
            cy = (a > ~b);
            y  = a + b + W'(cy);
         end
      end else begin : g_bad_impl
         $error("oc_fold_add: unknown ADD_IMPL");
      end
   endgenerate
endmodule

// File: rtl/oc_csum_accum.sv
module oc_csum_accum #(
   parameter int W        = 16,
   parameter int ADD_IMPL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         take,
   input  logic [W-1:0] word,
   output logic [W-1:0] acc_q,
   output logic [W-1:0] sum_nx
);
   logic [W-1:0] base;
   logic [W-1:0] add_res;

   assign base = clr ? '0 : acc_q;

   oc_fold_add #(.W(W), .ADD_IMPL(ADD_IMPL)) u_add (
      .a (base),
      .b (word),
      .y (add_res)
   );

   assign sum_nx = take ? add_res : base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= sum_nx;
   end

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !clr) |=> $stable(acc_q));

   assert_fold_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clr && acc_q != '0) |=> (acc_q != '0));

   assert_start_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && clr) |=> (acc_q == $past(word)));
endmodule

// File: rtl/oc_csum_result.sv
module oc_csum_result #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic         chk_mode,
   input  logic [W-1:0] sum,
   output logic [W-1:0] csum,
   output logic         pass,
   output logic         fail,
   output logic         done
);
   localparam logic [W-1:0] ALL_ONES = '1;

   logic total_ok;
   assign total_ok = (sum == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csum <= '0;
         pass <= 1'b0;
         fail <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= fire;
         if (fire) begin
            csum <= ~sum;
            pass <= chk_mode &&  total_ok;
            fail <= chk_mode && !total_ok;
         end
      end
   end

   assert_verdict_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail));

   assert_gen_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !chk_mode) |=> (!pass && !fail));

   assert_chk_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && chk_mode) |=> (pass || fail));
endmodule

// File: rtl/oc_csum_engine.sv
module oc_csum_engine #(
   parameter int W        = 16,
   parameter int ADD_IMPL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         in_mode,
   input  logic         in_valid,
   input  logic         in_last,
   input  logic [W-1:0] in_word,
   output logic [W-1:0] csum_out,
   output logic         pass,
   output logic         fail,
   output logic         done
);
   import oc_csum_pkg::*;

   cs_mode_e     mode;
   logic [W-1:0] acc_q;
   logic [W-1:0] sum_nx;
   logic         fire;

   assign mode = cs_mode_e'(in_mode);
   assign fire = in_valid && in_last;

   oc_csum_accum #(.W(W), .ADD_IMPL(ADD_IMPL)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start),
      .take   (in_valid),
      .word   (in_word),
      .acc_q  (acc_q),
      .sum_nx (sum_nx)
   );

   oc_csum_result #(.W(W)) u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .chk_mode (mode == CS_CHK),
      .sum      (sum_nx),
      .csum     (csum_out),
      .pass     (pass),
      .fail     (fail),
      .done     (done)
   );

   assert_done_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> done);

   assert_done_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !done);

   assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ($stable(csum_out) && $stable(pass) && $stable(fail)));
endmodule

// File: tb/oc_csum_engine_tb.sv
module oc_csum_engine_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, in_mode = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic [15:0] in_word = '0;
   logic [15:0] csum_out;
   logic        pass, fail, done;

   logic        start8 = 1'b0, mode8 = 1'b0, valid8 = 1'b0, last8 = 1'b0;
   logic [7:0]  word8 = '0;
   logic [7:0]  csum8;
   logic        pass8, fail8, done8;

   int cmp = 0;
   int mis = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   oc_csum_engine #(.W(16), .ADD_IMPL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_mode(in_mode),
      .in_valid(in_valid), .in_last(in_last), .in_word(in_word),
      .csum_out(csum_out), .pass(pass), .fail(fail), .done(done));

   oc_csum_engine #(.W(8), .ADD_IMPL(1)) u_dut_w8 (
      .clk(clk), .rst_n(rst_n), .start(start8), .in_mode(mode8),
      .in_valid(valid8), .in_last(last8), .in_word(word8),
      .csum_out(csum8), .pass(pass8), .fail(fail8), .done(done8));

   logic [15:0] msg [0:15];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      cmp++;
      if (!ok) begin
         mis++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int oc_add(input int a, input int b, input int w);
      int s;
      s = a + b;
      if (s >= (1 << w)) s = s - ((1 << w) - 1);
      return s;
   endfunction

   function automatic int model16(input int n);
      int s = 0;
      for (int i = 0; i < n; i++) s = oc_add(s, int'(msg[i]), 16);
      return s;
   endfunction

   task automatic run16(input int n, input logic md, input bit gaps,
                        output logic [15:0] cs, output logic ps, output logic fl,
                        output logic dn);
      for (int i = 0; i < n; i++) begin
         if (gaps && i > 0) begin
            @(negedge clk);
            start = 1'b0; in_valid = 1'b0; in_last = 1'b1; in_word = 16'hDEAD;
         end
         @(negedge clk);
         start = (i == 0); in_valid = 1'b1; in_last = (i == n - 1);
         in_word = msg[i]; in_mode = md;
      end
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      dn = done; cs = csum_out; ps = pass; fl = fail;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         mis++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
         $finish;
      end
   end

   initial begin
      logic [15:0] cs, cs_ref, cs_b;
      logic ps, fl, dn;
      int exp;

      repeat (3) @(negedge clk);
      // R12: reset state
      chk(done == 0 && pass == 0 && fail == 0, "R12 reset flags", {done, pass, fail}, 0);
      chk(csum_out == 16'h0, "R12 reset csum", csum_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: end-around carry cases
      msg[0] = 16'hFFFF; msg[1] = 16'h0001;
      run16(2, 1'b0, 0, cs, ps, fl, dn);
      chk(cs == 16'hFFFE, "R2 FFFF+0001", cs, 16'hFFFE);
      chk(dn == 1'b1, "R4 done after last", dn, 1);
      @(negedge clk);
      chk(done == 1'b0, "R4 done single cycle", done, 0);
      chk(csum_out == 16'hFFFE, "R4 output hold", csum_out, 16'hFFFE);
      msg[0] = 16'h8000; msg[1] = 16'h8000;
      run16(2, 1'b0, 0, cs, ps, fl, dn);
      chk(cs == 16'hFFFE, "R2 8000+8000", cs, 16'hFFFE);

      // R5 base message, R7 generate quiet
      msg[0] = 16'h1234; msg[1] = 16'hABCD; msg[2] = 16'h0F0F;
      msg[3] = 16'h8001; msg[4] = 16'hFFFE;
      exp = (~model16(5)) & 16'hFFFF;
      run16(5, 1'b0, 0, cs_ref, ps, fl, dn);
      chk(cs_ref == exp[15:0], "R5 generate", cs_ref, exp);
      chk(ps == 0 && fl == 0, "R7 gen no verdict", {ps, fl}, 0);

      // R1: a fresh start gives the same result with no reset in between
      run16(5, 1'b0, 0, cs, ps, fl, dn);
      chk(cs == cs_ref, "R1 restart clears", cs, cs_ref);

      // R3: idle cycles with junk data change nothing
      run16(5, 1'b0, 1, cs, ps, fl, dn);
      chk(cs == cs_ref, "R3 idle ignored", cs, cs_ref);

      // R6: message plus checksum passes
      msg[5] = cs_ref;
      run16(6, 1'b1, 0, cs, ps, fl, dn);
      chk(ps == 1 && fl == 0, "R6 check pass", {ps, fl}, 2);

      // R10: single bit flip fails
      msg[2] = msg[2] ^ 16'h0100;
      run16(6, 1'b1, 0, cs, ps, fl, dn);
      chk(ps == 0 && fl == 1, "R10 single flip fails", {ps, fl}, 1);
      msg[2] = msg[2] ^ 16'h0100;

      // R10: opposite flips of bit 0: word3 (bit0=1 ->0), word2 (bit0=1) use bit 4
      // bit 4: msg[0]=1234 has bit4=1, msg[2]=0F0F has bit4=0
      msg[0] = msg[0] ^ 16'h0010; msg[2] = msg[2] ^ 16'h0010;
      run16(6, 1'b1, 0, cs, ps, fl, dn);
      chk(ps == 1 && fl == 0, "R10 cancelling flips undetected", {ps, fl}, 2);
      msg[0] = msg[0] ^ 16'h0010; msg[2] = msg[2] ^ 16'h0010;

      // R8: swap words
      msg[0] = 16'hFFFE; msg[4] = 16'h1234;
      run16(5, 1'b0, 0, cs, ps, fl, dn);
      chk(cs == cs_ref, "R8 swap undetected", cs, cs_ref);
      msg[1] = 16'h8001; msg[3] = 16'hABCD;
      run16(5, 1'b0, 0, cs, ps, fl, dn);
      chk(cs == cs_ref, "R8 second swap undetected", cs, cs_ref);

      // R9: insert zero and all-ones words
      msg[5] = 16'h0000; msg[6] = 16'hFFFF; msg[7] = 16'h0000;
      run16(8, 1'b0, 0, cs, ps, fl, dn);
      chk(cs == cs_ref, "R9 zero/ones inserted", cs, cs_ref);
      msg[5] = msg[4]; msg[4] = 16'hFFFF; msg[6] = cs_ref;
      run16(7, 1'b1, 0, cs, ps, fl, dn);
      chk(ps == 1 && fl == 0, "R9 check with inserted ones", {ps, fl}, 2);

      // R6: all-zero message in check mode fails
      msg[0] = 16'h0000;
      run16(1, 1'b1, 0, cs, ps, fl, dn);
      chk(ps == 0 && fl == 1, "R6 zero total fails", {ps, fl}, 1);

      // R11: 8-bit sweep, two words per message
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b += 4) begin
            int s;
            logic md;
            md = logic'((a ^ b) & 1);
            s = oc_add(a, (b | (a & 3)), 8);
            @(negedge clk);
            start8 = 1'b1; valid8 = 1'b1; last8 = 1'b0; word8 = a[7:0]; mode8 = md;
            @(negedge clk);
            start8 = 1'b0; last8 = 1'b1; word8 = 8'((b | (a & 3)));
            @(negedge clk);
            valid8 = 1'b0; last8 = 1'b0;
            if (md == 1'b0)
               chk(done8 && csum8 == 8'(~s) && !pass8 && !fail8, "R11 w8 generate",
                   {done8, csum8}, {1'b1, 8'(~s)});
            else
               chk(done8 && pass8 == (s == 255) && fail8 == (s != 255), "R11 w8 check",
                   {done8, pass8, fail8}, {1'b1, s == 255, s != 255});
         end
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
      $finish;
   end
endmodule